// File: doc/BRIEF.md
# SPI Master Slave-Select Controller

This block drives the two slave-select outputs of an SPI master. A small control register holds a two-bit line choice, a polarity bit and a mode bit. In manual mode, software raises and drops each line directly through the line choice. In automatic mode, the line choice only names the target. That line is then framed around each transfer: it goes active when a go strobe starts the transfer and goes back to idle when the shift engine reports completion.

The shift engine sees a busy flag that rises on an accepted go strobe and falls on its done pulse. Software writes the register through a plain write port and reads the register and the busy flag back on a read bus. Only one slave is ever selected at a time. When both choice bits are set, line 0 takes priority.

Top module: `spi_ss_ctrl`

## Requirements
- R1: After reset the line choice, polarity bit, mode bit and busy flag are all 0, so both outputs sit at logic 1 and the read bus is 0.
- R2: A write with `cfg_we` high loads `cfg_wdata`, laid out as bit 3 mode (1 = automatic), bit 2 polarity, bits 1:0 line choice (bit k names line k). The read bus is `{busy, mode, polarity, choice[1:0]}` from the cycle after the write edge.
- R3: In manual mode, line k is active exactly when choice bit k is 1, whatever the busy flag.
- R4: In automatic mode, the chosen line is active exactly while the busy flag is 1, and every line is inactive while busy is 0.
- R5: When both choice bits are 1, only line 0 can be active. The two outputs are never active at the same time.
- R6: Polarity 1 makes the active level logic 1. Polarity 0 makes it logic 0. The idle level is the opposite one.
- R7: A go strobe while idle sets busy from the next cycle. A done pulse while busy clears it from the next cycle.
- R8: A go strobe while busy is ignored, and a single later done still clears busy. A done pulse while idle has no effect. Go and done in the same cycle while busy leave busy cleared.
- R9: A change of the polarity bit or the line choice shows on the outputs in the cycle right after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 4 | Write data: {mode, polarity, choice[1:0]} |
| cfg_rdata | output | 5 | Read data: {busy, mode, polarity, choice[1:0]} |
| go | input | 1 | Start-of-transfer strobe |
| xfer_done | input | 1 | End-of-transfer pulse from the shift engine |
| busy | output | 1 | Transfer in progress |
| ss_o | output | 2 | Slave-select pins, line 0 at bit 0 |

## Verification
The bench tries all sixteen register values, each with the busy flag idle and then set. Comparing the two busy states for the same value separates manual framing from automatic framing. Setting both choice bits separates the priority rule from a plain bitwise copy, and toggling the polarity bit shows that the inversion is applied to the whole output pair. Separate go/done sequences cover a go while busy, a done while idle and a go with a done in the same cycle, which tells the ignore rules apart from a free-running toggle.

// File: rtl/spi_ss_ctrl.sv
module spi_ss_ctrl #(
  parameter int LINES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [LINES+1:0] cfg_wdata,
  output logic [LINES+2:0] cfg_rdata,
  input  logic             go,
  input  logic             xfer_done,
  output logic             busy,
  output logic [LINES-1:0] ss_o
);
  logic [LINES-1:0] sel;
  logic             lvl, auto_md, busy_q;
  logic [LINES-1:0] pick, act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel     <= '0;
      lvl     <= 1'b0;
      auto_md <= 1'b0;
    end else if (cfg_we) begin
      sel     <= cfg_wdata[LINES-1:0];
      lvl     <= cfg_wdata[LINES];
      auto_md <= cfg_wdata[LINES+1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy_q <= 1'b0;
    else if (busy_q)    busy_q <= !xfer_done;
    else if (go)        busy_q <= 1'b1;
  end

  // lowest-numbered chosen line wins
  always_comb begin
    pick = '0;
    for (int k = LINES - 1; k >= 0; k--)
      if (sel[k]) pick = LINES'(1) << k;
  end

  assign act       = (auto_md && !busy_q) ? '0 : pick;
  assign ss_o      = lvl ? act : ~act;
  assign busy      = busy_q;
  assign cfg_rdata = {busy_q, auto_md, lvl, sel};
endmodule

module spi_ss_ctrl_chk #(
  parameter int LINES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LINES+2:0] cfg_rdata,
  input logic             go,
  input logic             xfer_done,
  input logic             busy,
  input logic [LINES-1:0] ss_o
);
  logic             lvl_r, auto_r;
  logic [LINES-1:0] act_r;
  assign lvl_r  = cfg_rdata[LINES];
  assign auto_r = cfg_rdata[LINES+1];
  assign act_r  = lvl_r ? ss_o : ~ss_o;

  assert_one_hot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_r));
  assert_auto_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_r && !busy) |-> (act_r == '0));
  assert_manual_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_r && cfg_rdata[0]) |-> act_r[0]);
  assert_busy_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && go) |=> busy);
  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer_done) |=> busy);
  assert_busy_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && xfer_done) |=> !busy);
  assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[LINES+2] == busy);
endmodule

bind spi_ss_ctrl spi_ss_ctrl_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .go(go),
  .xfer_done(xfer_done), .busy(busy), .ss_o(ss_o));

// File: tb/sim_spi_ss_ctrl.sv
module sim_spi_ss_ctrl;
  localparam int TCLK = 10;
  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, go = 1'b0, xfer_done = 1'b0;
  logic [3:0] cfg_wdata = '0;
  logic [4:0] cfg_rdata;
  logic       busy;
  logic [1:0] ss_o;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(TCLK/2) clk = ~clk;

  spi_ss_ctrl u0 (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .go(go), .xfer_done(xfer_done), .busy(busy), .ss_o(ss_o));

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick(logic we, logic [3:0] wd, logic g, logic d);
    @(negedge clk);
    cfg_we = we; cfg_wdata = wd; go = g; xfer_done = d;
    @(negedge clk);
    cfg_we = 0; go = 0; xfer_done = 0;
  endtask

  function automatic logic [1:0] exp_ss(logic [3:0] v, logic b);
    logic [1:0] a;
    a = v[0] ? 2'b01 : (v[1] ? 2'b10 : 2'b00);
    if (v[3] && !b) a = 2'b00;
    return v[2] ? a : ~a;
  endfunction

  initial begin
    #(TCLK * 3);
    chk("R1 ss", {6'b0, ss_o}, 8'h03);
    chk("R1 rdata", {3'b0, cfg_rdata}, 8'h00);
    rst_n = 1'b1;
    for (int v = 0; v < 16; v++) begin
      tick(1, 4'(v), 0, 0);
      chk("R2 rdata idle", {3'b0, cfg_rdata}, 8'(v));
      chk(v[3] ? "R4/R5/R6/R9 idle" : "R3/R5/R6/R9 idle", {6'b0, ss_o}, {6'b0, exp_ss(4'(v), 0)});
      tick(0, 0, 1, 0);
      chk("R7 busy set", {7'b0, busy}, 8'h01);
      chk(v[3] ? "R4/R5/R6 busy" : "R3/R5/R6 busy", {6'b0, ss_o}, {6'b0, exp_ss(4'(v), 1)});
      chk("R2 rdata busy", {3'b0, cfg_rdata}, 8'(v + 16));
      tick(0, 0, 0, 1);
      chk("R7 busy clear", {7'b0, busy}, 8'h00);
      chk("R4 after done", {6'b0, ss_o}, {6'b0, exp_ss(4'(v), 0)});
    end
    // R8 corner cases
    tick(1, 4'b1110, 0, 0);
    tick(0, 0, 0, 1);
    chk("R8 done idle", {7'b0, busy}, 8'h00);
    chk("R8 done idle ss", {6'b0, ss_o}, 8'h00);
    tick(0, 0, 1, 0);
    tick(0, 0, 1, 0);
    chk("R8 go busy", {7'b0, busy}, 8'h01);
    chk("R8 go busy ss", {6'b0, ss_o}, 8'h02);
    tick(0, 0, 0, 1);
    chk("R8 single done", {7'b0, busy}, 8'h00);
    tick(0, 0, 1, 0);
    tick(0, 0, 1, 1);
    chk("R8 go+done", {7'b0, busy}, 8'h00);
    // R9 polarity flip in manual mode
    tick(1, 4'b0001, 0, 0);
    chk("R9 low", {6'b0, ss_o}, 8'h02);
    @(negedge clk); cfg_we = 1; cfg_wdata = 4'b0101;
    @(posedge clk); #1;
    cfg_we = 0;
    chk("R9 next cycle", {6'b0, ss_o}, 8'h01);
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      #(TCLK * 100000) begin n_chk++; n_bad++; $display("FAIL watchdog expired"); end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule